// File: doc/BRIEF.md
# Clock Generator Power-Down Sequencer

This block governs the single shared power-good / power-down input of a clock generator and orders the shutdown and restart of its outputs. After reset the input is read as a power-good qualifier. Nothing runs until it has been seen high. From then on the same input is an active-low power-down request. The request is synchronized into the reference-clock domain. It is acted on only after two consecutive low samples.

An accepted request parks the outputs one by one. Each output is disabled at its own next falling edge, so no pulse is cut short. The PLL and oscillator enables are withdrawn only once every output is parked. A strap chooses whether parked single-ended outputs drive low or float. Differential outputs always drive both legs low when parked.

On release the sequencer turns the PLL and oscillator back on and waits for the lock flag. It then re-enables each output during that output's low phase. A timeout counter flags a lock that never arrives. The current sequencer state is reported on a status output.

Top module: `clkgen_pdn_seq`

## Requirements
- R1: While reset is applied and on the first cycle after it, the status reads power-good wait (code 0), every output enable is low and the PLL and oscillator enables are low.
- R2: In power-good wait a low input keeps the block in that state. Once the synchronized input is seen high, the block moves to relock (code 4) and raises the PLL and oscillator enables.
- R3: The input passes a two-stage synchronizer. A power-down request is accepted only when the synchronized input is low on two consecutive cycles, so a low pulse lasting one sample has no effect.
- R4: During parking (code 2), an enabled output is disabled only in a cycle where its level input was high at the previous sample and is low now. An output whose clock does not fall stays enabled and holds the block in parking.
- R5: A single-ended output i (bits 0 to N_SE-1 of the enable vector) reports high-impedance exactly when the strap input is high and output i is disabled. Differential outputs (the upper bits) have no high-impedance control and are parked low.
- R6: The PLL and oscillator enables drop only when the block enters off (code 3). That happens on the cycle after the last output enable has gone low. Both enables are low in off and in power-good wait, and are never low while any output is enabled.
- R7: In off, a high synchronized input moves the block to relock. In relock every output stays disabled until the lock flag is high, which moves the block to run (code 1).
- R8: In run, a disabled output is enabled in a cycle where its level input is low, never while it is high.
- R9: The lock error output rises after LOCK_TIMEOUT cycles spent in relock without lock. It stays high while the block remains in relock and is low in every other state.
- R10: An accepted power-down request during relock moves the block directly to off.
- R11: The status output encodes power-good wait as 0, run as 1, parking as 2, off as 3 and relock as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_pin_i | input | 1 | Shared power-good / active-low power-down input, asynchronous |
| strap_hiz_i | input | 1 | High: parked single-ended outputs float; low: they drive low |
| pll_lock_i | input | 1 | PLL lock flag |
| out_lvl_i | input | N_SE+N_DIFF | Current level of each output clock, single-ended first |
| out_en_o | output | N_SE+N_DIFF | Per-output enable |
| se_hiz_o | output | N_SE | Per single-ended output high-impedance control |
| pll_en_o | output | 1 | PLL enable |
| osc_en_o | output | 1 | Crystal oscillator enable |
| state_o | output | 3 | Sequencer state code |
| lock_err_o | output | 1 | Lock timeout error |

## Verification
The outputs are driven with free-running clocks of different periods, so each output parks and restarts in a different cycle. This separates a correct per-output falling-edge gate from a shared one. One output clock is then frozen high during parking, to show that shutdown waits for that output alone and that the PLL stays on meanwhile. The input pattern tries a single-sample low glitch against a held low, to show the two-sample acceptance. The lock flag is held low through a full timeout and then a power-down request is issued in relock. These show the error flag and the direct path to off. The strap is toggled while outputs are parked, which tells floating apart from driving low.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  typedef enum logic [2:0] {
    PS_PGWAIT = 3'd0,
    PS_RUN    = 3'd1,
    PS_PARK   = 3'd2,
    PS_OFF    = 3'd3,
    PS_RELOCK = 3'd4
  } pdn_state_e;
endpackage

// File: rtl/pdn_sync.sv
module pdn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic low2_o
);
  logic [STAGES-1:0] chain_q;
  logic              hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      hold_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      hold_q  <= chain_q[STAGES-1];
    end
  end

  assign q_o    = chain_q[STAGES-1];
  assign low2_o = ~chain_q[STAGES-1] & ~hold_q;
endmodule

// File: rtl/pdn_out_gate.sv
module pdn_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic run_i,
  input  logic park_i,
  output logic en_o
);
  logic en_q, en_d;
  logic lvl_q;
  logic fall;

  always_comb begin
    fall = lvl_q & ~lvl_i;
    en_d = en_q;
    if (!en_q && run_i && !lvl_i) begin
      en_d = 1'b1;
    end else if (en_q && park_i && fall) begin
      en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      lvl_q <= lvl_i;
    end
  end

  assign en_o = en_q;

  // R4
  park_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> ($past(lvl_i) == 1'b0 && $past(lvl_q) == 1'b1));

  // R8
  start_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> ($past(lvl_i) == 1'b0 && $past(run_i)));
endmodule

// File: rtl/pdn_lock_timer.sv
module pdn_lock_timer #(
  parameter int TIMEOUT = 450000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  output logic expired_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!active_i) begin
      cnt_d = '0;
    end else if (cnt_q == LIMIT) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = active_i & (cnt_q == LIMIT);

  // R9
  lock_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_i) |-> !expired_o);
endmodule

// File: rtl/clkgen_pdn_seq.sv
module clkgen_pdn_seq #(
  parameter int N_SE         = 4,
  parameter int N_DIFF       = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int LOCK_TIMEOUT = 450000
) (
  input  logic                     clk_ref,
  input  logic                     rst_n,
  input  logic                     pwr_pin_i,
  input  logic                     strap_hiz_i,
  input  logic                     pll_lock_i,
  input  logic [N_SE+N_DIFF-1:0]   out_lvl_i,
  output logic [N_SE+N_DIFF-1:0]   out_en_o,
  output logic [N_SE-1:0]          se_hiz_o,
  output logic                     pll_en_o,
  output logic                     osc_en_o,
  output logic [2:0]               state_o,
  output logic                     lock_err_o
);
  import pdn_pkg::*;

  localparam int N_OUT = N_SE + N_DIFF;

  pdn_state_e       state_q, state_d;
  logic             pin_hi;
  logic             pd_req;
  logic             all_parked;
  logic             run_req, park_req;
  logic [N_OUT-1:0] out_en;

  pdn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .d_i    (pwr_pin_i),
    .q_o    (pin_hi),
    .low2_o (pd_req)
  );

  assign run_req  = (state_q == PS_RUN);
  assign park_req = (state_q == PS_PARK);

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_gate
      pdn_out_gate u_gate (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .lvl_i  (out_lvl_i[gi]),
        .run_i  (run_req),
        .park_i (park_req),
        .en_o   (out_en[gi])
      );
    end
    for (gi = 0; gi < N_SE; gi++) begin : g_hiz
      assign se_hiz_o[gi] = strap_hiz_i & ~out_en[gi];
    end
  endgenerate

  assign all_parked = ~|out_en;

  pdn_lock_timer #(.TIMEOUT(LOCK_TIMEOUT)) u_timer (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .active_i  (state_q == PS_RELOCK),
    .expired_o (lock_err_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_PGWAIT: if (pin_hi)            state_d = PS_RELOCK;
      PS_RELOCK: if (pd_req)            state_d = PS_OFF;
                 else if (pll_lock_i)   state_d = PS_RUN;
      PS_RUN:    if (pd_req)            state_d = PS_PARK;
      PS_PARK:   if (all_parked)        state_d = PS_OFF;
      PS_OFF:    if (pin_hi)            state_d = PS_RELOCK;
      default:                          state_d = PS_PGWAIT;
    endcase
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_PGWAIT;
    end else begin
      state_q <= state_d;
    end
  end

  assign pll_en_o = (state_q == PS_RUN) || (state_q == PS_PARK) || (state_q == PS_RELOCK);
  assign osc_en_o = pll_en_o;
  assign out_en_o = out_en;
  assign state_o  = state_q;

  // R6
  osc_off_parked_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !pll_en_o |-> (out_en == '0));

  // R7
  relock_quiet_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (state_q == PS_RELOCK) |-> (out_en == '0));

  // R10
  relock_abort_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (state_q == PS_RELOCK && pd_req) |=> (state_q == PS_OFF));
endmodule

// File: tb/tb_clkgen_pdn_seq.sv
`timescale 1ns/1ps
module tb_clkgen_pdn_seq;
  localparam int N_SE  = 4;
  localparam int N_DIF = 2;
  localparam int N_OUT = N_SE + N_DIF;
  localparam int LT    = 64;

  logic clk = 1'b0;
  logic rst_n, pin, strap, lock;
  logic [N_OUT-1:0] out_lvl = '0;
  logic [N_OUT-1:0] out_en;
  logic [N_SE-1:0]  se_hiz;
  logic pll_en, osc_en, lock_err;
  logic [2:0] state;
  logic [N_OUT-1:0] freeze = '0;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  clkgen_pdn_seq #(.N_SE(N_SE), .N_DIFF(N_DIF), .SYNC_STAGES(2), .LOCK_TIMEOUT(LT)) dut (
    .clk_ref(clk), .rst_n(rst_n), .pwr_pin_i(pin), .strap_hiz_i(strap),
    .pll_lock_i(lock), .out_lvl_i(out_lvl), .out_en_o(out_en), .se_hiz_o(se_hiz),
    .pll_en_o(pll_en), .osc_en_o(osc_en), .state_o(state), .lock_err_o(lock_err)
  );

  // output clock sources: output i toggles every i+2 cycles unless frozen
  int div_cnt [N_OUT];
  always @(negedge clk) begin
    for (int i = 0; i < N_OUT; i++) begin
      div_cnt[i] = div_cnt[i] + 1;
      if (div_cnt[i] >= i + 2) begin
        div_cnt[i] = 0;
        if (!freeze[i]) out_lvl[i] = ~out_lvl[i];
      end
    end
  end

  // behavioural reference model
  int m_st;
  int m_rc;
  logic [N_OUT-1:0] m_en, m_plvl;
  int hist[$];

  always @(posedge clk or negedge rst_n) begin : model
    int s2, dly, nst;
    bit pdreq, all_off;
    logic [N_OUT-1:0] ne;
    if (!rst_n) begin
      m_st = 0; m_rc = 0; m_en = '0; m_plvl = '0;
      hist.delete();
      repeat (3) hist.push_back(0);
    end else begin
      s2 = hist[1]; dly = hist[2];
      pdreq = (s2 == 0) && (dly == 0);
      all_off = (m_en == '0);
      nst = m_st;
      case (m_st)
        0: if (s2 != 0) nst = 4;
        4: if (pdreq) nst = 3; else if (lock) nst = 1;
        1: if (pdreq) nst = 2;
        2: if (all_off) nst = 3;
        3: if (s2 != 0) nst = 4;
        default: nst = 0;
      endcase
      for (int i = 0; i < N_OUT; i++) begin
        ne[i] = m_en[i];
        if (!m_en[i] && m_st == 1 && !out_lvl[i]) ne[i] = 1'b1;
        else if (m_en[i] && m_st == 2 && m_plvl[i] && !out_lvl[i]) ne[i] = 1'b0;
      end
      if (m_st == 4) m_rc = (m_rc < LT) ? m_rc + 1 : m_rc;
      else m_rc = 0;
      m_plvl = out_lvl;
      m_en = ne;
      m_st = nst;
      hist.push_front(pin ? 1 : 0);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // every-cycle comparison against the model, 1 ns after the falling edge
  always begin
    @(negedge clk);
    #1;
    if (!done) begin
      cycles++;
      chk("R11", "state", 32'(state), 32'(m_st));
      chk("R4/R8", "out_en", 32'(out_en), 32'(m_en));
      chk("R5", "se_hiz", 32'(se_hiz), 32'({N_SE{strap}} & ~m_en[N_SE-1:0]));
      chk("R6", "pll_en", 32'(pll_en), 32'(m_st == 1 || m_st == 2 || m_st == 4));
      chk("R6", "osc_en", 32'(osc_en), 32'(m_st == 1 || m_st == 2 || m_st == 4));
      chk("R9", "lock_err", 32'(lock_err), 32'(m_st == 4 && m_rc == LT));
      if (cycles > 150000) begin
        mismatched++;
        $display("FAIL watchdog %s: actual hung expected finish", phase);
        done = 1;
        summary();
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input int code, input string req);
    int k;
    k = 0;
    while (state !== 3'(code) && k < 200) begin
      @(negedge clk); #1; k++;
    end
    chk(req, "state reached", 32'(state), 32'(code));
  endtask

  initial begin
    rst_n = 1'b0; pin = 1'b0; strap = 1'b0; lock = 1'b0;
    step(5);
    rst_n = 1'b1;
    step(1); #1;
    // R1 reset state
    phase = "R1";
    chk("R1", "status", 32'(state), 32'd0);
    chk("R1", "enables", 32'(out_en), 32'd0);
    chk("R1", "pll", 32'(pll_en), 32'd0);

    // R2 low input keeps power-good wait, high leaves it
    phase = "R2";
    step(10); #1;
    chk("R2", "still pg wait", 32'(state), 32'd0);
    step(1); pin = 1'b1;
    step(5); #1;
    chk("R2", "relock", 32'(state), 32'd4);
    chk("R2", "pll on", 32'(pll_en), 32'd1);

    // R7 outputs held off until lock
    phase = "R7";
    step(20); #1;
    chk("R7", "no enable before lock", 32'(out_en), 32'd0);
    step(1); lock = 1'b1;
    step(3); #1;
    chk("R7", "run after lock", 32'(state), 32'd1);
    // R8 every output comes up within a few of its own cycles
    phase = "R8";
    step(30); #1;
    chk("R8", "all enabled", 32'(out_en), 32'({N_OUT{1'b1}}));

    // R3 one-sample glitch ignored
    phase = "R3";
    step(1); pin = 1'b0;
    step(1); pin = 1'b1;
    step(10); #1;
    chk("R3", "glitch ignored", 32'(state), 32'd1);
    chk("R3", "outputs kept", 32'(out_en), 32'({N_OUT{1'b1}}));

    // R4 / R6 held low: park then off
    phase = "R4";
    step(1); pin = 1'b0; lock = 1'b0;
    wait_state(3, "R6");
    chk("R6", "pll off", 32'(pll_en), 32'd0);
    chk("R4", "all parked", 32'(out_en), 32'd0);

    // R5 strap selects float
    phase = "R5";
    step(1); strap = 1'b1;
    step(1); #1;
    chk("R5", "se float", 32'(se_hiz), 32'({N_SE{1'b1}}));
    step(1); strap = 1'b0;
    step(1); #1;
    chk("R5", "se drive low", 32'(se_hiz), 32'd0);

    // R7 release without lock then lock
    phase = "R7";
    step(1); pin = 1'b1;
    step(30); #1;
    chk("R7", "relock waits", 32'(state), 32'd4);
    chk("R7", "outputs off", 32'(out_en), 32'd0);
    step(1); lock = 1'b1;
    step(40); #1;
    chk("R8", "restart all", 32'(out_en), 32'({N_OUT{1'b1}}));

    // R4 frozen clock holds parking
    phase = "R4";
    while (1) begin
      @(negedge clk); #1;
      if (out_lvl[0]) break;
    end
    freeze[0] = 1'b1;
    step(1); pin = 1'b0; lock = 1'b0; strap = 1'b1;
    step(30); #1;
    chk("R4", "waits for falling edge", 32'(state), 32'd2);
    chk("R4", "frozen still on", 32'(out_en[0]), 32'd1);
    chk("R6", "pll held on", 32'(pll_en), 32'd1);
    freeze[0] = 1'b0;
    wait_state(3, "R4");

    // R9 lock timeout
    phase = "R9";
    step(1); pin = 1'b1;
    step(LT + 10); #1;
    chk("R9", "timeout flag", 32'(lock_err), 32'd1);
    chk("R9", "still relock", 32'(state), 32'd4);

    // R10 request during relock goes straight to off
    phase = "R10";
    step(1); pin = 1'b0;
    step(6); #1;
    chk("R10", "off from relock", 32'(state), 32'd3);
    chk("R9", "flag cleared", 32'(lock_err), 32'd0);

    phase = "R2";
    step(1); pin = 1'b1; lock = 1'b1; strap = 1'b0;
    wait_state(1, "R7");
    step(5);
    done = 1;
    summary();
  end
endmodule